// File: doc/BRIEF.md
# Sticky Status Trailer Word Generator

This block assembles the 16-bit trailer word that a serial sensor interface appends after a transfer of one or more data words. The upper four bits report chip and interface health. Three of them are error flags that latch. The fourth shows whether the current angle measurement is valid. The next four bits carry a response nibble that identifies the answering device. The low byte carries the check byte that the CRC stage supplies.

The three error flags are active low and sticky. A flag drops to 0 on its event strobe. It stays at 0 until the status register at address 0x00 is read over the serial link, which the surrounding logic reports as a one-cycle read strobe. The reset indicator comes out of reset at 0, so the first status read after power-up shows that a reset took place. A new event that lands in the same cycle as a status read wins, so that the event is never lost.

The word is formed directly from the flag registers and the live inputs. The serial shifter can load it in any cycle.

Top module: `status_trailer_gen`

## Requirements
- R1: After reset, bit 15 (reset indicator) is 0, and bits 14 and 13 are both 1.
- R2: A reset or watchdog event strobe (`wdg_evt`) makes bit 15 read 0 from the next clock cycle on. The bit stays 0 until a status-register read.
- R3: A system-error strobe (`sys_evt`) makes bit 14 read 0 from the next cycle on. The bit stays 0 until a status-register read.
- R4: An interface-access error strobe (`acc_evt`) makes bit 13 read 0 from the next cycle on. The bit stays 0 until a status-register read.
- R5: A status-register read strobe (`stat_rd`) returns each of bits 15, 14 and 13 to 1 in the next cycle, provided that the flag has no event in the same cycle.
- R6: When a flag's event and a status-register read occur in the same cycle, that flag reads 0 in the next cycle.
- R7: Bit 12 equals the `angle_ok` input in the same cycle, with no latching.
- R8: Bits 11:8 are one-cold. Bit 8+`dev_id` is 0 and the other three bits are 1.
- R9: Bits 7:0 equal `crc_in` in the same cycle.
- R10: An event on one error flag leaves the other two flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdg_evt | input | 1 | Chip reset / watchdog overflow event strobe |
| sys_evt | input | 1 | System error event strobe |
| acc_evt | input | 1 | Interface access error event strobe |
| stat_rd | input | 1 | Status register (address 0x00) has been read |
| angle_ok | input | 1 | Angle value valid level |
| dev_id | input | 2 | Device number selecting the low bit of the response nibble |
| crc_in | input | 8 | Check byte from the CRC stage |
| trailer | output | 16 | Assembled trailer word |

## Verification
The hardest case to reach is the collision between a status read and a fresh event on the same flag. In the same cycle, any other flags must be released. The stimulus table places a read together with a system-error strobe while the interface-access flag is also latched. The expected word then shows one flag still low and the other released. A later row repeats the collision on the reset indicator. Rows also step `dev_id` through all four values while changing the check byte and the angle level, so that the combinational fields are seen next to every flag state.

// File: rtl/status_trailer_gen.sv
module status_trailer_gen #(
  parameter int NIB_W = 4,
  parameter int CRC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wdg_evt,
  input  logic                     sys_evt,
  input  logic                     acc_evt,
  input  logic                     stat_rd,
  input  logic                     angle_ok,
  input  logic [$clog2(NIB_W)-1:0] dev_id,
  input  logic [CRC_W-1:0]         crc_in,
  output logic [3+NIB_W+CRC_W:0]   trailer
);
  localparam int          NFLAG    = 3;
  localparam logic [NFLAG-1:0] FLAG_INIT = 3'b011;

  logic [NFLAG-1:0] evt;
  logic [NFLAG-1:0] flag_q;
  logic [NIB_W-1:0] resp;

  assign evt = {wdg_evt, sys_evt, acc_evt};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[f] <= FLAG_INIT[f];
      else if (evt[f])     flag_q[f] <= 1'b0;
      else if (stat_rd)    flag_q[f] <= 1'b1;
    end
  end

  for (genvar i = 0; i < NIB_W; i++) begin : g_resp
    assign resp[i] = (dev_id != i);
  end

  assign trailer = {flag_q, angle_ok, resp, crc_in};
endmodule

module status_trailer_chk #(
  parameter int NIB_W = 4,
  parameter int CRC_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wdg_evt,
  input logic                     sys_evt,
  input logic                     acc_evt,
  input logic                     stat_rd,
  input logic [3+NIB_W+CRC_W:0]   trailer
);
  localparam int TOP = 3 + NIB_W + CRC_W;

  a_r2_wdg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_evt |=> !trailer[TOP]);
  a_r3_sys_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sys_evt |=> !trailer[TOP-1]);
  a_r4_acc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !trailer[TOP-2]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sys_evt) |=> trailer[TOP-1]);
  a_r3_sys_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!trailer[TOP-1] && !stat_rd) |=> !trailer[TOP-1]);
  a_r4_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!trailer[TOP-2] && !stat_rd) |=> !trailer[TOP-2]);
  a_r8_one_cold: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(trailer[CRC_W+NIB_W-1:CRC_W]) == NIB_W - 1);
endmodule

bind status_trailer_gen status_trailer_chk #(.NIB_W(NIB_W), .CRC_W(CRC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wdg_evt(wdg_evt), .sys_evt(sys_evt),
  .acc_evt(acc_evt), .stat_rd(stat_rd), .trailer(trailer));

// File: tb/status_trailer_gen_tb.sv
module status_trailer_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdg_evt = 0, sys_evt = 0, acc_evt = 0, stat_rd = 0, angle_ok = 0;
  logic [1:0]  dev_id = 0;
  logic [7:0]  crc_in = 0;
  logic [15:0] trailer;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_trailer_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wdg_evt(wdg_evt), .sys_evt(sys_evt),
    .acc_evt(acc_evt), .stat_rd(stat_rd), .angle_ok(angle_ok),
    .dev_id(dev_id), .crc_in(crc_in), .trailer(trailer));

  // {wdg, sys, acc, rd, angle, dev[1:0], crc[7:0], expected[15:0]}
  localparam int NV = 11;
  localparam logic [30:0] VEC [NV] = '{
    {5'b0000_1, 2'd0, 8'hA5, 16'h7EA5},
    {5'b0001_0, 2'd1, 8'h3C, 16'hED3C},
    {5'b0100_1, 2'd2, 8'h00, 16'hBB00},
    {5'b0000_1, 2'd3, 8'hFF, 16'hB7FF},
    {5'b0010_1, 2'd3, 8'h12, 16'h9712},
    {5'b0101_0, 2'd0, 8'h34, 16'hAE34},
    {5'b0001_0, 2'd0, 8'h56, 16'hEE56},
    {5'b1000_1, 2'd1, 8'h78, 16'h7D78},
    {5'b0000_1, 2'd1, 8'h9A, 16'h7D9A},
    {5'b1001_1, 2'd1, 8'hBC, 16'h7DBC},
    {5'b0001_1, 2'd2, 8'hDE, 16'hFBDE}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", trailer, 16'h6E00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", trailer, 16'h6E00);

    for (int v = 0; v < NV; v++) begin
      {wdg_evt, sys_evt, acc_evt, stat_rd, angle_ok} = VEC[v][30:26];
      dev_id = VEC[v][25:24];
      crc_in = VEC[v][23:16];
      @(posedge clk); #1;
      chk("R2/R3/R4/R5/R6/R10 flags", {trailer[15:13], 13'h0}, {VEC[v][15:13], 13'h0});
      chk("R7 angle bit", {15'h0, trailer[12]}, {15'h0, VEC[v][12]});
      chk("R8 response nibble", {12'h0, trailer[11:8]}, {12'h0, VEC[v][11:8]});
      chk("R9 crc byte", {8'h0, trailer[7:0]}, {8'h0, VEC[v][7:0]});
      @(negedge clk);
    end

    {wdg_evt, sys_evt, acc_evt, stat_rd} = 4'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", trailer[15:13] == 3'b011 ? 16'h1 : 16'h0, 16'h1);
    rst_n = 1'b1;
    acc_evt = 1'b1;
    @(posedge clk); #1;
    acc_evt = 1'b0;
    chk("R4 acc sets", {13'h0, trailer[15:13]}, 16'h2);
    repeat (3) @(posedge clk); #1;
    chk("R4 acc sticky", {13'h0, trailer[15:13]}, 16'h2);
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
    chk("R5 read releases all", {13'h0, trailer[15:13]}, 16'h7);

    done = 1;
    finish_run();
  end
endmodule